// File: doc/BRIEF.md
# Test-Mode Acoustic Channel Emulator

This block stands in for the acoustic path between an anti-noise speaker and an error microphone when the canceller runs in self-test. It receives one beat per sample tick. Each beat carries a noise sample, an anti-noise sample and an externally digitised error sample. The block forms an emulated residue and sends it on as one beat. To form the residue, it adds the noise sample, the anti-noise sample seen through a direct path with a programmable delay, and the anti-noise sample seen through one reflected path. The reflected path has its own delay and a power-of-two attenuation.

Both paths tap one shared anti-noise history that is 64 samples deep. That depth covers acoustic delays of around 10 ms at sample rates in the low kHz range. When self-test is off, the external error sample passes through untouched, so the canceller downstream sees the real microphone. Input and output are valid/ready streams. A beat is taken when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output beat holds, and no new input is taken. The configuration pins are plain levels, sampled in the cycle a beat is accepted.

Top module: `residue_channel_emu`

## Requirements
- R1: After reset, `out_valid` is 0, `in_ready` is 1, and every stored anti-noise history entry reads as zero.
- R2: A beat accepted in cycle t appears on `out_residue` with `out_valid` high from cycle t+1. `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, `out_valid` and `out_residue` stay unchanged.
- R3: When `test_mode` is 0 at acceptance, the output beat equals `in_adc` of that beat.
- R4: When `test_mode` is 1, the direct term is the anti-noise sample from `direct_dly` accepted beats earlier. A value of 0 selects the current beat's `in_anti`. All samples are signed two's complement 8-bit.
- R5: The reflected term is the anti-noise sample from `refl_dly` accepted beats earlier, arithmetically shifted right by `refl_shift` bits (0 to 6).
- R6: The reflected term is zero when `refl_en` is 0 or `refl_shift` is 7.
- R7: The sum of noise, direct term and reflected term is formed without overflow. It is then clamped to the range -128 to +127.
- R8: The history advances only on accepted beats, in both modes. `in_anti` presented without acceptance is never stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| test_mode | input | 1 | 1: emulate the channel; 0: pass `in_adc` through |
| direct_dly | input | 6 | Direct-path delay in accepted beats |
| refl_dly | input | 6 | Reflected-path delay in accepted beats |
| refl_shift | input | 3 | Reflection attenuation as a right shift; 7 clears the term |
| refl_en | input | 1 | Enable for the reflected term |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat can be accepted |
| in_noise | input | 8 | Noise sample, signed |
| in_anti | input | 8 | Anti-noise sample, signed |
| in_adc | input | 8 | External error sample, signed |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the output beat |
| out_residue | output | 8 | Residue sample, signed |

## Verification
The bench targets several corner cases:

- **Maximum delay of 63 right after reset.** This must read zeros. A history that is not cleared would leak X or stale data.
- **Delay 0.** This must select the live input sample. An off-by-one tap would return the previous beat.
- **Sums driven past +127 and below -128.** A plain 8-bit adder would wrap these around to the opposite sign.
- **Reflection shift of 7 and reflection disabled.** Either must give a zero reflected term. A design that shifts by 7 would leave -1 for negative samples.
- **Idle cycles with changing anti-noise.** A history that shifts on every clock, rather than on accepted beats, would misalign every later tap.
- **Random back-pressure.** This catches output beats that change or get lost while stalled.

// File: rtl/res_emu_pkg.sv
package res_emu_pkg;
  // Saturation bounds for a signed word of width w, held at width sw
  function automatic logic signed [15:0] sat_hi(input int w);
    return 16'((1 << (w - 1)) - 1);
  endfunction
endpackage

// File: rtl/anti_hist_line.sv
module anti_hist_line #(
  parameter int W     = 8,
  parameter int DEPTH = 64,
  parameter int NTAP  = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       adv,
  input  logic [W-1:0]               din,
  input  logic [NTAP-1:0][AW-1:0]    tap_sel,
  output logic [NTAP-1:0][W-1:0]     tap_out
);
  // hist[k] holds the sample accepted k+1 beats ago
  logic [W-1:0] hist [DEPTH-1];
  logic [W-1:0] view [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH - 1; i++) hist[i] <= '0;
    end else if (adv) begin
      hist[0] <= din;
      for (int i = 1; i < DEPTH - 1; i++) hist[i] <= hist[i-1];
    end
  end

  assign view[0] = din;
  for (genvar k = 1; k < DEPTH; k++) begin : g_view
    assign view[k] = hist[k-1];
  end

  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    assign tap_out[t] = view[tap_sel[t]];
  end
endmodule

// File: rtl/refl_atten.sv
module refl_atten #(
  parameter int W   = 8,
  parameter int SHW = 3
) (
  input  logic [W-1:0]   din,
  input  logic [SHW-1:0] shift,
  input  logic           en,
  output logic [W-1:0]   dout
);
  logic clear;
  assign clear = !en || (shift == {SHW{1'b1}});
  assign dout  = clear ? '0 : W'($signed(din) >>> shift);
endmodule

// File: rtl/resid_sum_sat.sv
module resid_sum_sat #(
  parameter int W = 8,
  localparam int SW = W + 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  localparam logic signed [SW-1:0] HI = SW'(res_emu_pkg::sat_hi(W));
  localparam logic signed [SW-1:0] LO = ~HI;

  logic signed [SW-1:0] wide;
  assign wide = $signed({{2{a[W-1]}}, a}) + $signed({{2{b[W-1]}}, b})
              + $signed({{2{c[W-1]}}, c});

  always_comb begin
    if (wide > HI)      y = HI[W-1:0];
    else if (wide < LO) y = LO[W-1:0];
    else                y = wide[W-1:0];
  end
endmodule

// File: rtl/residue_channel_emu.sv
module residue_channel_emu #(
  parameter int W     = 8,
  parameter int DEPTH = 64,
  parameter int SHW   = 3,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           test_mode,
  input  logic [AW-1:0]  direct_dly,
  input  logic [AW-1:0]  refl_dly,
  input  logic [SHW-1:0] refl_shift,
  input  logic           refl_en,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_noise,
  input  logic [W-1:0]   in_anti,
  input  logic [W-1:0]   in_adc,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W-1:0]   out_residue
);
  localparam int NTAP = 2;

  logic                    take;
  logic [NTAP-1:0][AW-1:0] sel;
  logic [NTAP-1:0][W-1:0]  taps;
  logic [W-1:0]            direct_term, refl_term, emu_sum, next_res;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign sel[0]   = direct_dly;
  assign sel[1]   = refl_dly;

  anti_hist_line #(.W(W), .DEPTH(DEPTH), .NTAP(NTAP)) u_hist (
    .clk(clk), .rst_n(rst_n), .adv(take), .din(in_anti),
    .tap_sel(sel), .tap_out(taps)
  );

  assign direct_term = taps[0];

  refl_atten #(.W(W), .SHW(SHW)) u_att (
    .din(taps[1]), .shift(refl_shift), .en(refl_en), .dout(refl_term)
  );

  resid_sum_sat #(.W(W)) u_sum (
    .a(in_noise), .b(direct_term), .c(refl_term), .y(emu_sum)
  );

  assign next_res = test_mode ? emu_sum : in_adc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_residue <= '0;
    end else begin
      if (take) begin
        out_valid   <= 1'b1;
        out_residue <= next_res;
      end else if (out_ready) begin
        out_valid   <= 1'b0;
      end
    end
  end

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_residue));
  // R2
  valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));
  // R3
  bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !test_mode |=> out_residue == $past(in_adc));
  // R4
  direct_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    direct_dly == '0 |-> direct_term == in_anti);
  // R6
  refl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!refl_en || refl_shift == {SHW{1'b1}}) |-> refl_term == '0);
endmodule

// File: tb/tb_residue_channel_emu.sv
module tb_residue_channel_emu;
  localparam int W = 8, DEPTH = 64, AW = 6, SHW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic           test_mode = 0, refl_en = 0, in_valid = 0, out_ready = 0;
  logic [AW-1:0]  direct_dly = '0, refl_dly = '0;
  logic [SHW-1:0] refl_shift = '0;
  logic [W-1:0]   in_noise = '0, in_anti = '0, in_adc = '0;
  logic           in_ready, out_valid;
  logic [W-1:0]   out_residue;

  residue_channel_emu dut (
    .clk(clk), .rst_n(rst_n), .test_mode(test_mode), .direct_dly(direct_dly),
    .refl_dly(refl_dly), .refl_shift(refl_shift), .refl_en(refl_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_noise(in_noise),
    .in_anti(in_anti), .in_adc(in_adc), .out_valid(out_valid),
    .out_ready(out_ready), .out_residue(out_residue)
  );

  int n_chk = 0, n_bad = 0;
  bit done = 0, bp_on = 0;
  logic [W-1:0] mh [DEPTH];   // mh[k]: anti sample accepted k beats ago
  logic [W-1:0] exp_q [$];
  string        tag_q [$];
  bit           hold_v = 0;
  logic [W-1:0] hold_d;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int sx(logic [W-1:0] v);
    return int'($signed(v));
  endfunction

  function automatic int tapv(int d, logic [W-1:0] cur);
    return (d == 0) ? sx(cur) : sx(mh[d]);
  endfunction

  function automatic logic [W-1:0] model(output string tag);
    int dir, rfl, s;
    if (!test_mode) begin
      tag = "R3";
      return in_adc;
    end
    dir = tapv(int'(direct_dly), in_anti);
    rfl = (refl_en && refl_shift != 3'd7) ? (tapv(int'(refl_dly), in_anti) >>> refl_shift) : 0;
    s = sx(in_noise) + dir + rfl;
    if (s > 127 || s < -128) tag = "R7";
    else if (!refl_en || refl_shift == 3'd7) tag = "R6/R4/R8";
    else tag = "R4/R5/R8";
    if (s > 127) s = 127;
    if (s < -128) s = -128;
    return W'(s);
  endfunction

  task automatic step();
    if (hold_v) begin
      chk(out_valid == 1'b1, "R2 hold valid", int'(out_valid), 1);
      chk(out_residue == hold_d, "R2 hold data", sx(out_residue), sx(hold_d));
    end
    chk(in_ready == (!out_valid || out_ready), "R2 ready", int'(in_ready),
        int'(!out_valid || out_ready));
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(0, "R2 spurious beat", sx(out_residue), 0);
      else begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(out_residue == e, t, sx(out_residue), sx(e));
      end
    end
    hold_v = out_valid && !out_ready;
    hold_d = out_residue;
  endtask

  task automatic send(int nz, int an, int ad, bit tm, int d0, int d1, int sh, bit en);
    bit acc;
    test_mode = tm; direct_dly = AW'(d0); refl_dly = AW'(d1);
    refl_shift = SHW'(sh); refl_en = en;
    in_noise = W'(nz); in_anti = W'(an); in_adc = W'(ad); in_valid = 1'b1;
    acc = 0;
    while (!acc) begin
      out_ready = bp_on ? ($urandom % 4 != 0) : 1'b1;
      #1;
      acc = in_ready;
      step();
      if (acc) begin
        string t;
        exp_q.push_back(model(t));
        tag_q.push_back(t);
        for (int k = DEPTH - 1; k >= 2; k--) mh[k] = mh[k-1];
        mh[1] = in_anti;
      end
      @(negedge clk);
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b0;
      in_anti = W'($urandom);
      out_ready = bp_on ? ($urandom % 2 != 0) : 1'b1;
      #1;
      step();
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL R2 watchdog act=hung exp=drained");
      summary();
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(24680);
    for (int k = 0; k < DEPTH; k++) mh[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(out_valid == 1'b0, "R1 out_valid", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R1 in_ready", int'(in_ready), 1);
    // R1 deepest taps read zero after reset
    send(17, 99, 0, 1, 63, 40, 0, 1);
    send(-5, 20, 0, 1, 62, 63, 1, 1);
    // R7 positive and negative clamps
    send(127, 127, 0, 1, 0, 0, 0, 0);
    send(-128, -128, 0, 1, 0, 0, 0, 1);
    send(100, 60, 0, 1, 0, 0, 1, 1);
    // R6 shift of 7 and disable with negative samples
    send(3, -100, 0, 1, 1, 0, 7, 1);
    send(3, -100, 0, 1, 1, 0, 2, 0);
    // R5 arithmetic shift of a negative reflection
    send(0, 0, 0, 1, 0, 2, 3, 1);
    // R3 bypass, history still advances (R8)
    send(0, 55, -77, 0, 0, 0, 0, 1);
    send(0, 66, 12, 0, 5, 5, 0, 1);
    // R8 idle cycles with changing anti must not shift history
    idle(5);
    send(0, 1, 0, 1, 1, 2, 0, 1);
    // random phase with back-pressure
    bp_on = 1;
    for (int n = 0; n < 2500; n++) begin
      int mode = $urandom % 8;
      send($urandom, $urandom, $urandom, mode != 0, $urandom % DEPTH,
           $urandom % DEPTH, $urandom % 8, mode != 1);
      if ($urandom % 5 == 0) idle(1 + $urandom % 3);
    end
    // drain
    bp_on = 0;
    in_valid = 1'b0;
    for (int i = 0; i < 10 && exp_q.size() > 0; i++) idle(1);
    chk(exp_q.size() == 0, "R2 drained", exp_q.size(), 0);
    done = 1;
    summary();
    $finish;
  end
endmodule